// File: doc/BRIEF.md
# Per-Port Switch Statistics Counter Bank

This block holds a set of traffic statistics for every port of a packet switch. Each port has 39 counters. Most of them are 32-bit frame or event counters: broadcast, multicast, pause, checksum errors, the frame-size bins, collisions and similar events. Three are 64-bit byte totals: good received bytes, bad received bytes and transmitted bytes. The MAC status logic raises a one-cycle strobe for each event. Frame and event strobes add one to their counter. Byte strobes add the frame length presented with them.

Software reads the counters through a simple 32-bit register port that returns data one cycle after the read. A control word does two things:

- It selects whether a read clears the low word's counter or leaves it as it is.
- It can start a flush, which walks every counter word of every port and clears it. While the flush runs, a busy flag reads back as set, and it drops by itself when the walk ends.

A separate enable word gates all counting.

Top module: `port_stat_bank`

## Requirements
- R1: Port p's counters sit in a 256-byte window at WIN_BASE + p*0x100, one 32-bit word every 4 bytes, 42 words from offset 0x00 to 0xA4. Counter c (c = 0..38) is at word c for c < 15. The 64-bit counters 15, 16 and 31 take the word pairs 15/16, 17/18 and 33/34, with the low word first. Counters 17..30 are at word c+2 and counters 32..38 are at word c+3. A read of offset 0xA8 or above in a window returns 0. Read data appears on reg_rdata the cycle after reg_rd and holds when no read is made.
- R2: Strobe bit p*39+c of ev_strobe adds 1 to 32-bit counter c of port p. For counters 15 and 16 it adds that port's rx_len slice instead, and for counter 31 it adds that port's tx_len slice.
- R3: Bit 0 of the enable word at EN_ADDR gates all counting. While it is 0, strobes have no effect. It reads back at bit 0.
- R4: When the keep bit is 0, a read of a counter's low word returns the value the counter held before that edge. The counter then restarts from that edge's own increment, so an event on the same edge is kept.
- R5: The control word at CTRL_ADDR has bit 0 busy, bit 1 flush (which reads 0) and bit 2 keep, and every write to it loads keep. When keep is 1, reads leave the counters unchanged.
- R6: The 64-bit counters carry from the low 32 bits into the high 32 bits. A read of the high word returns the high half captured at the most recent read of the same counter's low word.
- R7: Writing the control word with bits 1 and 0 both set while idle makes busy read 1 for exactly 42*NPORTS cycles, after which it reads 0. By then every counter of every port is zero.
- R8: A control write with the flush bit set and the busy bit clear starts no flush and leaves the counters unchanged.
- R9: Strobes that arrive while a flush runs are not counted, even for counters the flush has already cleared.
- R10: After reset, the enable word, the control word and every counter read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ev_strobe | input | NPORTS*39 | one-cycle event strobes, bit p*39+c for counter c of port p |
| rx_len | input | NPORTS*LENW | received frame length per port, used by byte strobes 15 and 16 |
| tx_len | input | NPORTS*LENW | transmitted frame length per port, used by byte strobe 31 |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | 16 | byte address of the register access |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, valid the cycle after reg_rd |

## Verification
The assertions check on every cycle four things:

- A valid flush command raises busy.
- A flush command without the busy bit leaves busy low.
- Busy never outlasts 42*NPORTS cycles and falls exactly at that count.
- Read data holds between reads, and unmapped window words read zero.

Only the bench scenarios can show the counting itself. That covers the word layout, the byte increments, the carry from the low to the high half, the latched high word, clear-on-read against keep, the event kept on the clearing edge, and whether strobes are dropped while counting is disabled or a flush is running.

// File: rtl/port_stat_bank.sv
module port_stat_bank #(
  parameter int NPORTS = 4,
  parameter int LENW = 16,
  parameter logic [15:0] WIN_BASE = 16'h1000,
  parameter logic [15:0] CTRL_ADDR = 16'h0030,
  parameter logic [15:0] EN_ADDR = 16'h0034
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS*39-1:0]   ev_strobe,
  input  logic [NPORTS*LENW-1:0] rx_len,
  input  logic [NPORTS*LENW-1:0] tx_len,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [15:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NCNT = 39;
  localparam int NWORD = 42;
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [8:0] NP9 = 9'(NPORTS);

  function automatic logic [7:0] wmap(input logic [5:0] w);
    logic [5:0] m2, m3;
    m2 = w - 6'd2;
    m3 = w - 6'd3;
    if (w < 6'd15)       return {2'b10, w};
    else if (w == 6'd15) return {2'b10, 6'd15};
    else if (w == 6'd16) return {2'b11, 6'd15};
    else if (w == 6'd17) return {2'b10, 6'd16};
    else if (w == 6'd18) return {2'b11, 6'd16};
    else if (w <= 6'd32) return {2'b10, m2};
    else if (w == 6'd33) return {2'b10, 6'd31};
    else if (w == 6'd34) return {2'b11, 6'd31};
    else if (w <= 6'd41) return {2'b10, m3};
    else                 return 8'd0;
  endfunction

  logic en, keep, busy;
  logic [PW-1:0] fl_p;
  logic [5:0] fl_w;

  logic [15:0] off;
  logic hit, rvalid, rhi;
  logic [PW-1:0] rp;
  logic [7:0] rm, fm;
  logic [5:0] ridx, fidx;
  logic [1:0] rk;

  assign off = reg_addr - WIN_BASE;
  assign hit = (reg_addr >= WIN_BASE) && ({1'b0, off[15:8]} < NP9) && (off[1:0] == 2'b00);
  assign rp = off[8 +: PW];
  assign rm = wmap(off[7:2]);
  assign rvalid = hit && rm[7];
  assign rhi = rm[6];
  assign ridx = rm[5:0];
  assign rk = (ridx == 6'd15) ? 2'd0 : (ridx == 6'd16) ? 2'd1 : 2'd2;
  assign fm = wmap(fl_w);
  assign fidx = fm[5:0];

  logic [63:0] cv [NPORTS][NCNT];
  logic [31:0] hl [NPORTS][3];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      logic [63:0] q, inc, nxt;
      logic ev, clr;
      if (c == 31) begin : g_tx
        assign inc = {{(64-LENW){1'b0}}, tx_len[p*LENW +: LENW]};
      end else if (c == 15 || c == 16) begin : g_rx
        assign inc = {{(64-LENW){1'b0}}, rx_len[p*LENW +: LENW]};
      end else begin : g_one
        assign inc = 64'd1;
      end
      assign ev = ev_strobe[p*NCNT + c] && en && !busy;
      assign clr = (busy && fl_p == PW'(p) && fidx == 6'(c)) ||
                   (reg_rd && rvalid && !rhi && !keep && rp == PW'(p) && ridx == 6'(c));
      assign nxt = (clr ? 64'd0 : q) + (ev ? inc : 64'd0);
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 64'd0;
        else if (clr || ev) begin
          if (c == 15 || c == 16 || c == 31) q <= nxt;
          else q <= {32'd0, nxt[31:0]};
        end
      end
      assign cv[p][c] = q;
    end

    for (genvar k = 0; k < 3; k++) begin : g_lat
      localparam int CI = (k == 0) ? 15 : ((k == 1) ? 16 : 31);
      logic [31:0] lat;
      always_ff @(posedge clk) begin
        if (!rst_n) lat <= 32'd0;
        else if (reg_rd && rvalid && !rhi && rp == PW'(p) && ridx == 6'(CI))
          lat <= cv[p][CI][63:32];
      end
      assign hl[p][k] = lat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      keep <= 1'b0;
      busy <= 1'b0;
      fl_p <= '0;
      fl_w <= '0;
    end else begin
      if (reg_wr && reg_addr == EN_ADDR) en <= reg_wdata[0];
      if (reg_wr && reg_addr == CTRL_ADDR) begin
        keep <= reg_wdata[2];
        if (reg_wdata[1] && reg_wdata[0] && !busy) begin
          busy <= 1'b1;
          fl_p <= '0;
          fl_w <= '0;
        end
      end
      if (busy) begin
        if (fl_w == 6'(NWORD - 1)) begin
          fl_w <= '0;
          if (fl_p == PW'(NPORTS - 1)) busy <= 1'b0;
          else fl_p <= fl_p + 1'b1;
        end else begin
          fl_w <= fl_w + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= 32'd0;
    else if (reg_rd) begin
      if (reg_addr == CTRL_ADDR)    reg_rdata <= {29'd0, keep, 1'b0, busy};
      else if (reg_addr == EN_ADDR) reg_rdata <= {31'd0, en};
      else if (rvalid)              reg_rdata <= rhi ? hl[rp][rk] : cv[rp][ridx][31:0];
      else                          reg_rdata <= 32'd0;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, reg_wdata[31:3], fm[7:6]};
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int NPORTS = 4,
  parameter logic [15:0] WIN_BASE = 16'h1000,
  parameter logic [15:0] CTRL_ADDR = 16'h0030
)(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        busy
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [15:0] TOTAL = 16'(NPORTS * 42);
  localparam logic [8:0] NP9 = 9'(NPORTS);

  logic [15:0] bcnt, off;
  logic flush_cmd, flush_only, gap_rd;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bcnt <= 16'd0;
    else bcnt <= bcnt + 16'd1;
  end

  assign off = reg_addr - WIN_BASE;
  assign flush_cmd = reg_wr && reg_addr == CTRL_ADDR && reg_wdata[1] && reg_wdata[0];
  assign flush_only = reg_wr && reg_addr == CTRL_ADDR && reg_wdata[1] && !reg_wdata[0];
  assign gap_rd = reg_rd && reg_addr >= WIN_BASE && ({1'b0, off[15:8]} < NP9) &&
                  off[1:0] == 2'b00 && off[7:2] >= 6'd42;

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_cmd && !busy) |=> busy);
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < TOTAL));
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == TOTAL));
  p_flush_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_only && !busy) |=> !busy);
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  p_gap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gap_rd |=> (reg_rdata == 32'd0));

  logic unused_ok;
  assign unused_ok = &{1'b0, reg_wdata[31:2]};
endmodule

bind port_stat_bank stat_bank_chk #(
  .NPORTS(NPORTS), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
);

// File: tb/sim_port_stat_bank.sv
module sim_port_stat_bank;
  timeunit 1ns; timeprecision 1ps;

  localparam int NP = 4;
  localparam int LW = 16;
  localparam int TOTAL = NP * 42;
  localparam logic [15:0] BASE = 16'h1000;
  localparam logic [15:0] CTRL = 16'h0030;
  localparam logic [15:0] ENA = 16'h0034;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP*39-1:0] ev_strobe = '0;
  logic [NP*LW-1:0] rx_len = '0, tx_len = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  port_stat_bank #(.NPORTS(NP), .LENW(LW), .WIN_BASE(BASE), .CTRL_ADDR(CTRL), .EN_ADDR(ENA)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .rx_len(rx_len), .tx_len(tx_len),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  always #5 clk = ~clk;

  // {port[63:62], counter[61:56], pulses[55:48], length[47:32], expected[31:0]}
  localparam logic [63:0] VEC [7] = '{
    {2'd0, 6'd0,  8'd3, 16'd0,    32'd3},
    {2'd1, 6'd7,  8'd5, 16'd0,    32'd5},
    {2'd3, 6'd38, 8'd2, 16'd0,    32'd2},
    {2'd2, 6'd15, 8'd2, 16'd1000, 32'd2000},
    {2'd0, 6'd31, 8'd3, 16'd1500, 32'd4500},
    {2'd1, 6'd16, 8'd4, 16'd64,   32'd256},
    {2'd2, 6'd22, 8'd1, 16'd0,    32'd1}
  };

  function automatic logic [15:0] caddr(int p, int c, bit hi);
    int w;
    if (c < 15) w = c;
    else if (c == 15) w = 15;
    else if (c == 16) w = 17;
    else if (c <= 30) w = c + 2;
    else if (c == 31) w = 33;
    else w = c + 3;
    if (hi) w = w + 1;
    return BASE + 16'(p * 256) + 16'(w * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic pulse(int p, int c, int len, int n);
    rx_len[p*LW +: LW] = LW'(len);
    tx_len[p*LW +: LW] = LW'(len);
    ev_strobe[p*39 + c] = 1'b1;
    repeat (n) @(negedge clk);
    ev_strobe[p*39 + c] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(ENA, v);  check("R10 enable after reset", v, 0);
    rd(CTRL, v); check("R10 control after reset", v, 0);
    rd(caddr(2, 31, 0), v); check("R10 counter after reset", v, 0);

    pulse(0, 1, 0, 2);
    rd(caddr(0, 1, 0), v); check("R3 counting disabled", v, 0);
    wr(ENA, 1);
    rd(ENA, v); check("R3 enable readback", v, 1);

    for (int i = 0; i < 7; i++) begin
      pulse(int'(VEC[i][63:62]), int'(VEC[i][61:56]), int'(VEC[i][47:32]), int'(VEC[i][55:48]));
      rd(caddr(int'(VEC[i][63:62]), int'(VEC[i][61:56]), 0), v);
      check("R2 vector count", v, VEC[i][31:0]);
      rd(caddr(int'(VEC[i][63:62]), int'(VEC[i][61:56]), 0), v);
      check("R4 cleared by read", v, 0);
    end

    rd(BASE + 16'h00A8, v); check("R1 unmapped word", v, 0);
    rd(BASE + 16'h03FC, v); check("R1 unmapped top word", v, 0);

    wr(CTRL, 32'h4);
    pulse(1, 3, 0, 4);
    rd(caddr(1, 3, 0), v); check("R5 keep first read", v, 4);
    rd(caddr(1, 3, 0), v); check("R5 keep second read", v, 4);
    rd(CTRL, v); check("R5 keep bit readback", v, 4);
    wr(CTRL, 32'h0);
    rd(caddr(1, 3, 0), v); check("R4 read after keep off", v, 4);

    pulse(1, 3, 0, 2);
    reg_rd = 1'b1; reg_addr = caddr(1, 3, 0); ev_strobe[1*39 + 3] = 1'b1;
    @(negedge clk);
    v = reg_rdata; reg_rd = 1'b0; ev_strobe[1*39 + 3] = 1'b0;
    check("R4 read with same-edge event", v, 2);
    rd(caddr(1, 3, 0), v); check("R4 same-edge event kept", v, 1);

    pulse(3, 31, 65535, 65537);
    pulse(3, 31, 1, 1);
    rd(caddr(3, 31, 0), v); check("R6 low word after carry", v, 0);
    rd(caddr(3, 31, 1), v); check("R6 high word carry", v, 1);
    rd(caddr(3, 31, 0), v); check("R6 low word after clear", v, 0);
    rd(caddr(3, 31, 1), v); check("R6 high word relatched", v, 0);

    pulse(2, 5, 0, 3);
    wr(CTRL, 32'h2);
    rd(CTRL, v); check("R8 flush without busy bit", v, 0);
    rd(caddr(2, 5, 0), v); check("R8 counter untouched", v, 3);

    pulse(2, 5, 0, 3);
    pulse(0, 10, 0, 6);
    pulse(3, 38, 0, 1);
    pulse(3, 15, 300, 2);
    wr(CTRL, 32'h3);
    pulse(0, 0, 0, 5);
    repeat (TOTAL - 6) @(negedge clk);
    rd(CTRL, v); check("R7 busy on last flush cycle", v, 1);
    rd(CTRL, v); check("R7 busy dropped", v, 0);
    rd(caddr(0, 10, 0), v); check("R7 port0 counter flushed", v, 0);
    rd(caddr(2, 5, 0), v);  check("R7 port2 counter flushed", v, 0);
    rd(caddr(3, 38, 0), v); check("R7 last counter flushed", v, 0);
    rd(caddr(3, 15, 0), v); check("R7 byte counter flushed", v, 0);
    rd(caddr(0, 0, 0), v);  check("R9 events during flush dropped", v, 0);

    pulse(0, 0, 0, 1);
    rd(caddr(0, 0, 0), v); check("R2 counting resumes after flush", v, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule